// File: doc/BRIEF.md
# Dual-port pixel output demultiplexer

This block sits at the end of a pixel pipeline and spreads a stream of pixel samples over one or two output ports. Each sample arrives with a valid strobe. A one-cycle line-start pulse marks the leading edge of horizontal sync. Three configuration bits choose the output arrangement:
- a port-count bit selects one port or two;
- a pairing bit selects whether, with two ports, the pixels alternate between them or each pair is shown on both at once;
- a phase bit selects which port receives the first pixel of a line.

A data-clock enable marks each cycle in which new output data is presented. Port B has an output-enable flag, and Port B reads zero while that flag is low.

The configuration bits are sampled only on the line-start pulse, so a pixel pair is never split by a mode change in the middle of a line. The sample in the line-start cycle is already handled under the new bits. The input has no back-pressure: the block accepts a sample in every cycle in which the valid strobe is high, so there is no ready signal. Reset selects two ports, paired output and Port A first.

Top module: `pix_demux_out`

## Requirements
- R1: With one port selected, every valid sample appears on `port_a` in the cycle after it is accepted, and `dclk_en` is high in that same cycle.
- R2: With one port selected, `port_b_oe` is 0, `port_b` reads 0, and the pairing bit has no effect on `port_a` or `dclk_en`.
- R3: With two ports in alternating mode (pairing bit 0), each valid sample appears on its own port one cycle after it is accepted, with `dclk_en` high. The other port keeps its value.
- R4: With two ports in paired mode (pairing bit 1), the first sample of a pair changes no output and leaves `dclk_en` low. One cycle after the second sample is accepted, both ports update together and `dclk_en` is high.
- R5: With the phase bit at 1, the first sample after line start and every later odd-numbered sample go to Port A. The even-numbered samples go to Port B.
- R6: With the phase bit at 0, the assignment is swapped: odd-numbered samples, including the first one, go to Port B, and even-numbered samples go to Port A.
- R7: Line start restarts the odd/even count. A sample accepted in the line-start cycle is sample 1. A pair left incomplete at the end of a line is discarded and never shown.
- R8: The configuration bits are captured only in a line-start cycle. Changes at any other time have no effect until the next line start.
- R9: After reset, `port_a` = 0, `port_b` = 0, `dclk_en` = 0 and `port_b_oe` = 1. Until the first line start, the block works with two ports, paired output and Port A first.
- R10: A cycle with `pix_valid` low produces `dclk_en` = 0 in the next cycle and leaves both ports unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Sample on `pix_data` is accepted this cycle |
| pix_data | input | W (8) | Pixel sample |
| line_start | input | 1 | One-cycle pulse at the horizontal sync leading edge |
| cfg_dual | input | 1 | 1 = two output ports, 0 = Port A only |
| cfg_together | input | 1 | With two ports: 1 = pair shown on both ports at once, 0 = alternate |
| cfg_a_first | input | 1 | 1 = first sample of a line to Port A, 0 = to Port B |
| port_a | output | W (8) | Port A data |
| port_b | output | W (8) | Port B data, reads 0 while disabled |
| port_b_oe | output | 1 | Port B drive enable |
| dclk_en | output | 1 | New output data presented this cycle |

## Verification
The assertions assume three things about the inputs: `line_start` is a single-cycle pulse, the configuration bits matter only in a line-start cycle, and `pix_data` is ignored while `pix_valid` is low. The stimulus changes the configuration bits in the middle of a line and drives junk data on cycles without a valid sample, so that these cases are shown to have no effect. Lines end on odd sample counts in both alternating and paired modes, and one line start coincides with a valid sample, so that the restart of the odd/even count and the discarding of an incomplete pair are visible at the ports.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  typedef struct packed {
    logic dual;
    logic together;
    logic a_first;
  } pdm_mode_t;

  localparam pdm_mode_t PDM_MODE_RESET = '{dual: 1'b1, together: 1'b1, a_first: 1'b1};
endpackage

// File: rtl/pdm_mode_latch.sv
module pdm_mode_latch
  import pdm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      line_start,
  input  pdm_mode_t cfg,
  output pdm_mode_t eff_mode
);
  pdm_mode_t act_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          act_q <= PDM_MODE_RESET;
    else if (line_start) act_q <= cfg;
  end

  // The sample taken in the line-start cycle already follows the new bits.
  always_comb eff_mode = line_start ? cfg : act_q;

  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(act_q));
endmodule

// File: rtl/pdm_pair_track.sv
module pdm_pair_track
  import pdm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      line_start,
  input  logic      pix_valid,
  input  pdm_mode_t eff_mode,
  output logic      cur_odd,
  output logic      to_a
);
  logic odd_next_q;

  always_comb begin
    cur_odd = line_start | odd_next_q;
    to_a    = (cur_odd == eff_mode.a_first);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          odd_next_q <= 1'b1;
    else if (pix_valid)  odd_next_q <= ~cur_odd;
    else if (line_start) odd_next_q <= 1'b1;
  end

  // R7: inside a line, successive samples alternate between odd and even.
  assert_parity_alt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !line_start) ##1 (pix_valid && !line_start) |-> cur_odd != $past(cur_odd));
endmodule

// File: rtl/pdm_out_stage.sv
module pdm_out_stage
  import pdm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pix_valid,
  input  logic [W-1:0] pix_data,
  input  pdm_mode_t    eff_mode,
  input  logic         cur_odd,
  input  logic         to_a,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q,
  output logic         en_q,
  output logic         oe_q
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      held_q <= '0;
      en_q   <= 1'b0;
      oe_q   <= PDM_MODE_RESET.dual;
    end else begin
      oe_q <= eff_mode.dual;
      en_q <= 1'b0;
      if (pix_valid) begin
        if (!eff_mode.dual) begin
          a_q  <= pix_data;
          en_q <= 1'b1;
        end else if (!eff_mode.together) begin
          if (to_a) a_q <= pix_data;
          else      b_q <= pix_data;
          en_q <= 1'b1;
        end else if (cur_odd) begin
          held_q <= pix_data;
        end else begin
          if (to_a) begin
            a_q <= pix_data;
            b_q <= held_q;
          end else begin
            a_q <= held_q;
            b_q <= pix_data;
          end
          en_q <= 1'b1;
        end
      end
    end
  end

  assert_single_to_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !eff_mode.dual |=> en_q && (a_q == $past(pix_data)));

  assert_alt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && eff_mode.dual && !eff_mode.together && to_a |=> $stable(b_q) && en_q);

  assert_pair_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && eff_mode.dual && eff_mode.together && cur_odd
      |=> !en_q && $stable(a_q) && $stable(b_q));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !en_q && $stable(a_q) && $stable(b_q));
endmodule

// File: rtl/pix_demux_out.sv
module pix_demux_out
  import pdm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pix_valid,
  input  logic [W-1:0] pix_data,
  input  logic         line_start,
  input  logic         cfg_dual,
  input  logic         cfg_together,
  input  logic         cfg_a_first,
  output logic [W-1:0] port_a,
  output logic [W-1:0] port_b,
  output logic         port_b_oe,
  output logic         dclk_en
);
  pdm_mode_t    cfg, eff_mode;
  logic         cur_odd, to_a;
  logic [W-1:0] b_q;

  always_comb cfg = '{dual: cfg_dual, together: cfg_together, a_first: cfg_a_first};

  pdm_mode_latch u_mode (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .cfg(cfg), .eff_mode(eff_mode)
  );

  pdm_pair_track u_pair (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .pix_valid(pix_valid),
    .eff_mode(eff_mode), .cur_odd(cur_odd), .to_a(to_a)
  );

  pdm_out_stage #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .eff_mode(eff_mode), .cur_odd(cur_odd), .to_a(to_a),
    .a_q(port_a), .b_q(b_q), .en_q(dclk_en), .oe_q(port_b_oe)
  );

  // A disabled Port B reads zero.
  always_comb port_b = port_b_oe ? b_q : '0;

  assert_b_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !port_b_oe |-> port_b == '0);
endmodule

// File: tb/pix_demux_out_tb.sv
module pix_demux_out_tb;
  localparam int W = 8;
  localparam int NV = 23;

  typedef struct packed {
    logic         ls;
    logic         v;
    logic [7:0]   d;
    logic         dual;
    logic         tog;
    logic         af;
    logic [7:0]   ea;
    logic [7:0]   eb;
    logic         eoe;
    logic         een;
    logic [3:0]   req;
  } vec_t;

  // Fields: ls, v, d, dual, tog, a_first | exp_a, exp_b, exp_oe, exp_en, requirement.
  localparam vec_t VECS [NV] = '{
    // single port line, configuration changed mid-line (R1, R2, R8)
    '{1'b1,1'b1,8'h11,1'b0,1'b1,1'b1, 8'h11,8'h00,1'b0,1'b1, 4'd1},
    '{1'b0,1'b1,8'h12,1'b1,1'b1,1'b1, 8'h12,8'h00,1'b0,1'b1, 4'd8},
    '{1'b0,1'b0,8'h99,1'b1,1'b1,1'b1, 8'h12,8'h00,1'b0,1'b0, 4'd10},
    '{1'b0,1'b1,8'h13,1'b1,1'b0,1'b1, 8'h13,8'h00,1'b0,1'b1, 4'd2},
    // alternating, Port A first (R3, R5)
    '{1'b1,1'b0,8'h00,1'b1,1'b0,1'b1, 8'h13,8'h00,1'b1,1'b0, 4'd3},
    '{1'b0,1'b1,8'h21,1'b1,1'b0,1'b1, 8'h21,8'h00,1'b1,1'b1, 4'd5},
    '{1'b0,1'b1,8'h22,1'b1,1'b0,1'b1, 8'h21,8'h22,1'b1,1'b1, 4'd5},
    '{1'b0,1'b1,8'h23,1'b1,1'b0,1'b1, 8'h23,8'h22,1'b1,1'b1, 4'd3},
    // alternating, Port B first, sample on line-start cycle (R6, R7)
    '{1'b1,1'b1,8'h31,1'b1,1'b0,1'b0, 8'h23,8'h31,1'b1,1'b1, 4'd6},
    '{1'b0,1'b1,8'h32,1'b1,1'b0,1'b0, 8'h32,8'h31,1'b1,1'b1, 4'd6},
    '{1'b0,1'b0,8'hAA,1'b1,1'b0,1'b0, 8'h32,8'h31,1'b1,1'b0, 4'd10},
    '{1'b0,1'b1,8'h33,1'b1,1'b0,1'b0, 8'h32,8'h33,1'b1,1'b1, 4'd6},
    // paired, Port A first (R4, R5)
    '{1'b1,1'b1,8'h41,1'b1,1'b1,1'b1, 8'h32,8'h33,1'b1,1'b0, 4'd4},
    '{1'b0,1'b1,8'h42,1'b1,1'b1,1'b1, 8'h41,8'h42,1'b1,1'b1, 4'd4},
    '{1'b0,1'b1,8'h43,1'b1,1'b1,1'b1, 8'h41,8'h42,1'b1,1'b0, 4'd4},
    '{1'b0,1'b0,8'h55,1'b1,1'b1,1'b1, 8'h41,8'h42,1'b1,1'b0, 4'd10},
    '{1'b0,1'b1,8'h44,1'b1,1'b1,1'b1, 8'h43,8'h44,1'b1,1'b1, 4'd5},
    '{1'b0,1'b1,8'h45,1'b1,1'b1,1'b1, 8'h43,8'h44,1'b1,1'b0, 4'd4},
    // paired, Port B first; the dangling 0x45 is dropped (R6, R7)
    '{1'b1,1'b1,8'h51,1'b1,1'b1,1'b0, 8'h43,8'h44,1'b1,1'b0, 4'd7},
    '{1'b0,1'b1,8'h52,1'b1,1'b1,1'b0, 8'h52,8'h51,1'b1,1'b1, 4'd7},
    '{1'b0,1'b1,8'h53,1'b1,1'b1,1'b0, 8'h52,8'h51,1'b1,1'b0, 4'd6},
    '{1'b0,1'b1,8'h54,1'b1,1'b1,1'b0, 8'h54,8'h53,1'b1,1'b1, 4'd6},
    // back to single port (R2)
    '{1'b1,1'b1,8'h61,1'b0,1'b0,1'b0, 8'h61,8'h00,1'b0,1'b1, 4'd2}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pix_valid = 1'b0;
  logic [W-1:0] pix_data = '0;
  logic         line_start = 1'b0;
  logic         cfg_dual = 1'b0, cfg_together = 1'b0, cfg_a_first = 1'b0;
  logic [W-1:0] port_a, port_b;
  logic         port_b_oe, dclk_en;
  int           checks = 0;
  int           errors = 0;

  always #2.5 clk = ~clk;

  pix_demux_out #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .line_start(line_start), .cfg_dual(cfg_dual), .cfg_together(cfg_together),
    .cfg_a_first(cfg_a_first), .port_a(port_a), .port_b(port_b),
    .port_b_oe(port_b_oe), .dclk_en(dclk_en)
  );

  task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic drive(input logic ls, input logic v, input logic [7:0] d,
                       input logic du, input logic tg, input logic af);
    @(negedge clk);
    line_start = ls; pix_valid = v; pix_data = d;
    cfg_dual = du; cfg_together = tg; cfg_a_first = af;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; line_start = 1'b0; pix_valid = 1'b0; pix_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    // R9: reset state
    check("R9 port_a", port_a, 8'h00);
    check("R9 port_b", port_b, 8'h00);
    check("R9 port_b_oe", {7'd0, port_b_oe}, 8'h01);
    check("R9 dclk_en", {7'd0, dclk_en}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].ls, VECS[i].v, VECS[i].d, VECS[i].dual, VECS[i].tog, VECS[i].af);
      check($sformatf("R%0d vec%0d port_a", VECS[i].req, i), port_a, VECS[i].ea);
      check($sformatf("R%0d vec%0d port_b", VECS[i].req, i), port_b, VECS[i].eb);
      check($sformatf("R%0d vec%0d port_b_oe", VECS[i].req, i), {7'd0, port_b_oe}, {7'd0, VECS[i].eoe});
      check($sformatf("R%0d vec%0d dclk_en", VECS[i].req, i), {7'd0, dclk_en}, {7'd0, VECS[i].een});
    end

    // R9: default mode before any line start is paired with Port A first.
    // The configuration inputs are set to single port to show they are unused.
    do_reset();
    drive(1'b0, 1'b1, 8'h71, 1'b0, 1'b0, 1'b0);
    check("R9 default pair first dclk_en", {7'd0, dclk_en}, 8'h00);
    check("R9 default pair first port_a", port_a, 8'h00);
    drive(1'b0, 1'b1, 8'h72, 1'b0, 1'b0, 1'b0);
    check("R9 default pair port_a", port_a, 8'h71);
    check("R9 default pair port_b", port_b, 8'h72);
    check("R9 default pair dclk_en", {7'd0, dclk_en}, 8'h01);

    // R7: an odd count in alternating mode does not shift the next line.
    drive(1'b1, 1'b1, 8'h81, 1'b1, 1'b0, 1'b1);
    check("R7 alt s1 port_a", port_a, 8'h81);
    drive(1'b0, 1'b1, 8'h82, 1'b1, 1'b0, 1'b1);
    check("R7 alt s2 port_b", port_b, 8'h82);
    drive(1'b0, 1'b1, 8'h83, 1'b1, 1'b0, 1'b1);
    check("R7 alt s3 port_a", port_a, 8'h83);
    drive(1'b1, 1'b1, 8'h84, 1'b1, 1'b0, 1'b1);
    check("R7 new line first port_a", port_a, 8'h84);
    check("R7 new line first port_b", port_b, 8'h82);
    drive(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1);
    check("R10 idle dclk_en", {7'd0, dclk_en}, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule